// File: doc/BRIEF.md
# Checkpointed CAM Rename Map

This block renames destination registers for an out-of-order core that has no reorder buffer. The map is indexed by physical register. Each physical entry holds the logical register it names, a live bit and a pending-release bit. A separate one-bit-per-register pool records which physical registers can be handed out. When a destination is renamed, the lowest free physical register is taken. The entry that held the same logical register until then stops being live and is marked pending-release. It is not freed at once.

Checkpoints replace the reorder buffer. Saving a checkpoint copies only two vectors into a slot: the live bits and the pending-release bits. The pending-release bits are then cleared. Committing a slot returns every register in its saved pending-release vector to the pool, in one cycle. Restoring the youngest slot reloads the live bits, clears the pending-release bits, and returns to the pool every register that was allocated after that checkpoint. A source operand is found by a CAM match of a logical tag against the live entries.

Top module: `cam_rename_map`

## Requirements
- R1: After reset, logical register i is mapped to physical register i for every i below NUM_LOG. Physical registers NUM_LOG and above are free, and no register is pending-release.
- R2: An accepted allocation (alloc_valid and alloc_ready high at a clock edge) takes the lowest-numbered free physical register, which alloc_preg shows in the same cycle. From the next cycle on, that register is no longer free and lookups of the requested logical tag return it.
- R3: alloc_ready is low whenever no physical register is free. A request made then changes no state.
- R4: An accepted allocation marks the previous live mapping of the same logical register as pending-release, and that register stays unavailable to later allocations. Several stale mappings of one logical register can be pending at once, and all of them are freed together by one commit.
- R5: lkp_preg gives the physical index of the one live entry whose logical tag equals lkp_ltag, combinationally from the current state.
- R6: ckpt_save stores the live and pending-release vectors as they were before that cycle's edge, into slot ckpt_save_slot, and clears all pending-release bits. An allocation in the same cycle is not in the snapshot, and its stale mapping is left pending-release for the following interval.
- R7: ckpt_commit returns every register in slot ckpt_commit_slot's saved pending-release vector to the free pool, and allocations can take them from the next cycle on.
- R8: ckpt_restore targets the most recent saved checkpoint. It reloads the live vector from slot ckpt_restore_slot, clears all pending-release bits, and frees every register that is live or pending-release now but was not live in the snapshot. alloc_ready is low during that cycle and no allocation is made.
- R9: A commit takes full effect in the same cycle as an allocation, a save or a restore. The freed set is the union of both effects.
- R10: In legal use (commit oldest first, restore only the youngest), no physical register is ever both free and live.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Request to rename one destination |
| alloc_ltag | input | $clog2(NUM_LOG) | Logical destination register |
| alloc_ready | output | 1 | A free register exists and no restore is in progress |
| alloc_preg | output | $clog2(NUM_PHYS) | Physical register granted |
| lkp_ltag | input | $clog2(NUM_LOG) | Logical source register to look up |
| lkp_preg | output | $clog2(NUM_PHYS) | Physical register currently live for lkp_ltag |
| ckpt_save | input | 1 | Take a checkpoint |
| ckpt_save_slot | input | $clog2(NUM_CKPT) | Slot written by the save |
| ckpt_commit | input | 1 | Commit a checkpoint |
| ckpt_commit_slot | input | $clog2(NUM_CKPT) | Slot whose pending-release vector is freed |
| ckpt_restore | input | 1 | Roll back to a checkpoint |
| ckpt_restore_slot | input | $clog2(NUM_CKPT) | Slot whose live vector is reloaded |

## Verification
Three pairs of operations can share a cycle and are provoked on purpose: an allocation with a save, an allocation with a commit, and a restore with a commit. The first pair is judged by committing the new slot later and checking that the register made stale in the save cycle is not freed until the following commit. The other two pairs are judged by the next granted index and by lookups, which show whether both free sets arrived. A behavioural model compares alloc_ready, alloc_preg and lkp_preg on every cycle, through directed sequences and a long stretch of legal random traffic.

// File: rtl/rmap_pkg.sv
// Package: operation selector shared by the rename map modules.
package rmap_pkg;
    // Map update mode: normal step or rollback restore.
    typedef enum logic {
        MAP_STEP    = 1'b0,
        MAP_RESTORE = 1'b1
    } map_op_e;
endpackage

// File: rtl/rmap_cam.sv
// rmap_cam: physical-indexed CAM of logical tags with a live bit and a
// pending-release bit per entry. It provides two match ports, one for a
// source lookup and one for the previous mapping of an allocation.
// Assumes: exactly one live entry per logical tag, and wr_preg names a free
// register whenever wr_en is high.
module rmap_cam
    import rmap_pkg::*;
#(
    parameter int NP = 16,
    parameter int NL = 8,
    localparam int PW = $clog2(NP),
    localparam int LW = $clog2(NL)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  map_op_e       op,
    input  logic          wr_en,
    input  logic [LW-1:0] wr_ltag,
    input  logic [PW-1:0] wr_preg,
    input  logic          ff_clear,
    input  logic [NP-1:0] restore_valid,
    input  logic [LW-1:0] lkp_ltag,
    output logic [PW-1:0] lkp_preg,
    output logic [NP-1:0] valid_o,
    output logic [NP-1:0] ff_o
);
    logic [LW-1:0] tag_q [NP];
    logic [NP-1:0] valid_q, ff_q, valid_d, ff_d;
    logic [NP-1:0] lkp_match, prev_match;
    logic [PW-1:0] prev_idx;
    logic          prev_hit;

    // Per-entry comparators for both match ports.
    for (genvar g = 0; g < NP; g++) begin : g_match
        assign lkp_match[g]  = valid_q[g] && (tag_q[g] == lkp_ltag);
        assign prev_match[g] = valid_q[g] && (tag_q[g] == wr_ltag);
    end

    // Encode the one-hot match vectors into indices.
    always_comb begin
        lkp_preg = '0;
        prev_idx = '0;
        for (int p = 0; p < NP; p++) begin
            if (lkp_match[p])  lkp_preg = lkp_preg | PW'(p);
            if (prev_match[p]) prev_idx = prev_idx | PW'(p);
        end
        prev_hit = |prev_match;
    end

    // Next live and pending-release vectors.
    always_comb begin
        valid_d = valid_q;
        ff_d    = ff_clear ? '0 : ff_q;
        if (wr_en) begin
            if (prev_hit) begin
                valid_d[prev_idx] = 1'b0;
                ff_d[prev_idx]    = 1'b1;
            end
            valid_d[wr_preg] = 1'b1;
        end
        if (op == MAP_RESTORE) begin
            valid_d = restore_valid;
            ff_d    = '0;
        end
    end

    // Live and pending-release registers, identity map after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NP; p++) valid_q[p] <= (p < NL);
            ff_q <= '0;
        end else begin
            valid_q <= valid_d;
            ff_q    <= ff_d;
        end
    end

    // Logical tag storage, written on allocation only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NP; p++) tag_q[p] <= LW'(p % NL);
        end else if (wr_en && op == MAP_STEP) begin
            tag_q[wr_preg] <= wr_ltag;
        end
    end

    assign valid_o = valid_q;
    assign ff_o    = ff_q;

    // R5: a lookup sees exactly one live entry per logical tag.
    a_r5_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(lkp_match));
    // R4: the stale mapping becomes pending-release and not live.
    a_r4_stale_marked: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && prev_hit && op == MAP_STEP) |=>
            (ff_q[$past(prev_idx)] && !valid_q[$past(prev_idx)]));
    // R6: a save with no same-cycle stale mapping leaves nothing pending.
    a_r6_ff_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (op == MAP_STEP && ff_clear && !(wr_en && prev_hit)) |=> (ff_q == '0));
    // R8: a restore reloads the live vector.
    a_r8_valid_restored: assert property (@(posedge clk) disable iff (!rst_n)
        (op == MAP_RESTORE) |=> (valid_q == $past(restore_valid)));
endmodule

// File: rtl/rmap_freelist.sv
// rmap_freelist: one bit per physical register marking it free. Offers the
// lowest-numbered free register and accepts a release vector every cycle.
// Assumes: released registers are never the one taken in the same cycle.
module rmap_freelist #(
    parameter int NP = 16,
    parameter int NL = 8,
    localparam int PW = $clog2(NP)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic [NP-1:0] release_i,
    output logic          any_free,
    output logic [PW-1:0] pick_idx,
    output logic [NP-1:0] free_o
);
    logic [NP-1:0] free_q, free_d;

    // Lowest-index priority pick.
    always_comb begin
        pick_idx = '0;
        for (int p = NP - 1; p >= 0; p--) begin
            if (free_q[p]) pick_idx = PW'(p);
        end
        any_free = |free_q;
    end

    // Apply releases, then remove the granted register.
    always_comb begin
        free_d = free_q | release_i;
        if (take) free_d[pick_idx] = 1'b0;
    end

    // Pool register: everything above the identity map starts free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NP; p++) free_q[p] <= (p >= NL);
        end else begin
            free_q <= free_d;
        end
    end

    assign free_o = free_q;

    // R2: a granted register is no longer free afterwards.
    a_r2_taken_not_free: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !free_q[$past(pick_idx)]);
    // R7: every released register is free afterwards.
    a_r7_released_free: assert property (@(posedge clk) disable iff (!rst_n)
        (release_i != '0) |=> ((free_q & $past(release_i)) == $past(release_i)));
endmodule

// File: rtl/rmap_ckpt_store.sv
// rmap_ckpt_store: checkpoint slots, each holding a live vector and a
// pending-release vector. One write port and two independent read ports
// (commit and restore). Reads return contents from before the edge.
module rmap_ckpt_store #(
    parameter int NP = 16,
    parameter int NC = 4,
    localparam int CW = $clog2(NC)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [CW-1:0] wr_slot,
    input  logic [NP-1:0] wr_valid,
    input  logic [NP-1:0] wr_ff,
    input  logic [CW-1:0] cmt_slot,
    output logic [NP-1:0] cmt_ff,
    input  logic [CW-1:0] rst_slot,
    output logic [NP-1:0] rst_valid
);
    logic [NP-1:0] sv_q [NC];
    logic [NP-1:0] sf_q [NC];

    // Slot storage, cleared on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NC; c++) begin
                sv_q[c] <= '0;
                sf_q[c] <= '0;
            end
        end else if (wr_en) begin
            sv_q[wr_slot] <= wr_valid;
            sf_q[wr_slot] <= wr_ff;
        end
    end

    assign cmt_ff    = sf_q[cmt_slot];
    assign rst_valid = sv_q[rst_slot];
endmodule

// File: rtl/cam_rename_map.sv
// cam_rename_map: rename map without a reorder buffer. Allocates physical
// destinations, tracks stale mappings as pending-release, and saves, commits
// or restores checkpoints of two bits per physical register.
// Assumes: commits go oldest first; restore targets the youngest live slot;
// NUM_PHYS > NUM_LOG.
module cam_rename_map
    import rmap_pkg::*;
#(
    parameter int NUM_PHYS = 16,
    parameter int NUM_LOG  = 8,
    parameter int NUM_CKPT = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        alloc_valid,
    input  logic [$clog2(NUM_LOG)-1:0]  alloc_ltag,
    output logic                        alloc_ready,
    output logic [$clog2(NUM_PHYS)-1:0] alloc_preg,
    input  logic [$clog2(NUM_LOG)-1:0]  lkp_ltag,
    output logic [$clog2(NUM_PHYS)-1:0] lkp_preg,
    input  logic                        ckpt_save,
    input  logic [$clog2(NUM_CKPT)-1:0] ckpt_save_slot,
    input  logic                        ckpt_commit,
    input  logic [$clog2(NUM_CKPT)-1:0] ckpt_commit_slot,
    input  logic                        ckpt_restore,
    input  logic [$clog2(NUM_CKPT)-1:0] ckpt_restore_slot
);
    localparam int PW = $clog2(NUM_PHYS);

    logic                any_free, fire, save_en;
    logic [PW-1:0]       pick_idx;
    logic [NUM_PHYS-1:0] valid_v, ff_v, free_v, snap_ff, snap_valid, rel_v;
    map_op_e             op;

    // Grant and operation decode; a restore blocks allocation and saving.
    always_comb begin
        alloc_ready = any_free && !ckpt_restore;
        fire        = alloc_valid && alloc_ready;
        save_en     = ckpt_save && !ckpt_restore;
        op          = ckpt_restore ? MAP_RESTORE : MAP_STEP;
    end

    // Release vector: committed slot plus registers allocated since restore point.
    always_comb begin
        rel_v = '0;
        if (ckpt_restore) rel_v = (valid_v | ff_v) & ~snap_valid;
        if (ckpt_commit)  rel_v = rel_v | snap_ff;
    end

    assign alloc_preg = pick_idx;

    rmap_cam #(.NP(NUM_PHYS), .NL(NUM_LOG)) cam_i (
        .clk(clk), .rst_n(rst_n), .op(op), .wr_en(fire),
        .wr_ltag(alloc_ltag), .wr_preg(pick_idx), .ff_clear(save_en),
        .restore_valid(snap_valid), .lkp_ltag(lkp_ltag), .lkp_preg(lkp_preg),
        .valid_o(valid_v), .ff_o(ff_v)
    );

    rmap_freelist #(.NP(NUM_PHYS), .NL(NUM_LOG)) pool_i (
        .clk(clk), .rst_n(rst_n), .take(fire), .release_i(rel_v),
        .any_free(any_free), .pick_idx(pick_idx), .free_o(free_v)
    );

    rmap_ckpt_store #(.NP(NUM_PHYS), .NC(NUM_CKPT)) ckpt_i (
        .clk(clk), .rst_n(rst_n), .wr_en(save_en), .wr_slot(ckpt_save_slot),
        .wr_valid(valid_v), .wr_ff(ff_v),
        .cmt_slot(ckpt_commit_slot), .cmt_ff(snap_ff),
        .rst_slot(ckpt_restore_slot), .rst_valid(snap_valid)
    );

    // R10: no register is both free and live.
    a_r10_free_excl_valid: assert property (@(posedge clk) disable iff (!rst_n)
        ((free_v & valid_v) == '0));
    // R3: no grant while the pool is empty.
    a_r3_no_grant_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (free_v == '0) |-> !alloc_ready);
endmodule

// File: tb/cam_rename_map_tb_top.sv
// Bench: a behavioural model of the map compared against the outputs each cycle.
module cam_rename_map_tb_top;
    localparam int NP = 16;
    localparam int NL = 8;
    localparam int NC = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic alloc_valid = 1'b0;
    logic [2:0] alloc_ltag = '0;
    logic alloc_ready;
    logic [3:0] alloc_preg;
    logic [2:0] lkp_ltag = '0;
    logic [3:0] lkp_preg;
    logic ckpt_save = 1'b0, ckpt_commit = 1'b0, ckpt_restore = 1'b0;
    logic [1:0] ckpt_save_slot = '0, ckpt_commit_slot = '0, ckpt_restore_slot = '0;

    always #4 clk = ~clk;

    cam_rename_map #(.NUM_PHYS(NP), .NUM_LOG(NL), .NUM_CKPT(NC)) dut_i (
        .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_ltag(alloc_ltag),
        .alloc_ready(alloc_ready), .alloc_preg(alloc_preg), .lkp_ltag(lkp_ltag),
        .lkp_preg(lkp_preg), .ckpt_save(ckpt_save), .ckpt_save_slot(ckpt_save_slot),
        .ckpt_commit(ckpt_commit), .ckpt_commit_slot(ckpt_commit_slot),
        .ckpt_restore(ckpt_restore), .ckpt_restore_slot(ckpt_restore_slot)
    );

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    // Model state
    int m_tag[NP];
    bit m_valid[NP], m_ff[NP], m_free[NP];
    bit s_v[NC][NP], s_f[NC][NP];
    int live[$];

    function automatic void model_reset();
        for (int p = 0; p < NP; p++) begin
            m_tag[p] = p % NL; m_valid[p] = (p < NL); m_ff[p] = 0; m_free[p] = (p >= NL);
        end
        for (int c = 0; c < NC; c++)
            for (int p = 0; p < NP; p++) begin s_v[c][p] = 0; s_f[c][p] = 0; end
    endfunction

    function automatic int low_free();
        for (int p = 0; p < NP; p++) if (m_free[p]) return p;
        return -1;
    endfunction

    function automatic int find_live(int t);
        for (int p = 0; p < NP; p++) if (m_valid[p] && m_tag[p] == t) return p;
        return -1;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic void model_step(bit a, int lt, bit sv, int ss, bit cm, int cs, bit rs, int rss);
        bit pre_v[NP], pre_f[NP], cff[NP];
        for (int p = 0; p < NP; p++) begin
            pre_v[p] = m_valid[p]; pre_f[p] = m_ff[p]; cff[p] = cm ? s_f[cs][p] : 1'b0;
        end
        if (rs) begin
            for (int p = 0; p < NP; p++) begin
                if ((pre_v[p] || pre_f[p]) && !s_v[rss][p]) m_free[p] = 1;
                if (cff[p]) m_free[p] = 1;
                m_valid[p] = s_v[rss][p];
                m_ff[p] = 0;
            end
        end else begin
            int nw, old;
            nw = low_free();
            old = find_live(lt);
            if (sv) for (int p = 0; p < NP; p++) begin
                s_v[ss][p] = pre_v[p]; s_f[ss][p] = pre_f[p]; m_ff[p] = 0;
            end
            if (a && nw >= 0) begin
                if (old >= 0) begin m_valid[old] = 0; m_ff[old] = 1; end
                m_valid[nw] = 1; m_tag[nw] = lt; m_free[nw] = 0;
            end
            for (int p = 0; p < NP; p++) if (cff[p]) m_free[p] = 1;
        end
    endfunction

    task automatic step(bit a, int lt, bit sv, int ss, bit cm, int cs,
                        bit rs, int rss, int lk, string req);
        int lf;
        alloc_valid = a; alloc_ltag = 3'(lt);
        ckpt_save = sv; ckpt_save_slot = 2'(ss);
        ckpt_commit = cm; ckpt_commit_slot = 2'(cs);
        ckpt_restore = rs; ckpt_restore_slot = 2'(rss);
        lkp_ltag = 3'(lk);
        @(negedge clk);
        lf = low_free();
        chk(req, "alloc_ready", int'(alloc_ready), int'(!rs && lf >= 0));
        if (!rs && lf >= 0) chk(req, "alloc_preg", int'(alloc_preg), lf);
        chk("R5", "lkp_preg", int'(lkp_preg), find_live(lk));
        model_step(a, lt, sv, ss, cm, cs, rs, rss);
        @(posedge clk); #1;
    endtask

    task automatic idle(int lk, string req);
        step(0, 0, 0, 0, 0, 0, 0, 0, lk, req);
    endtask

    // Watchdog: a hung run counts as a miscompare and still reports.
    initial begin
        #(8 * 200000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1: identity map and pool after reset
        for (int i = 0; i < NL; i++) idle(i, "R1");
        // R2: grant lowest free register; lookup follows next cycle
        step(1, 3, 0, 0, 0, 0, 0, 0, 3, "R2");
        idle(3, "R2");
        // R4: two more renames of tag 3 leave several stale mappings
        step(1, 3, 0, 0, 0, 0, 0, 0, 3, "R4");
        step(1, 3, 0, 0, 0, 0, 0, 0, 3, "R4");
        step(1, 5, 0, 0, 0, 0, 0, 0, 5, "R4");
        // R6: save slot 0, then save slot 1 together with an allocation
        step(0, 0, 1, 0, 0, 0, 0, 0, 3, "R6");
        step(1, 6, 1, 1, 0, 0, 0, 0, 6, "R6");
        step(1, 6, 0, 0, 0, 0, 0, 0, 6, "R6");
        // R7: commit slot 0 frees the stale registers together
        step(0, 0, 0, 0, 1, 0, 0, 0, 3, "R7");
        idle(3, "R7");
        // R9: commit slot 1 with an allocation in the same cycle
        step(1, 2, 1, 2, 1, 1, 0, 0, 2, "R9");
        step(1, 2, 0, 0, 0, 0, 0, 0, 2, "R9");
        // R3: drain the pool, then ask with nothing free
        for (int i = 0; i < NP; i++) step(1, i % NL, 0, 0, 0, 0, 0, 0, i % NL, "R3");
        step(1, 4, 0, 0, 0, 0, 0, 0, 4, "R3");
        idle(4, "R3");
        // R8: restore slot 2 with an allocation request held high
        step(1, 1, 0, 0, 0, 0, 1, 2, 1, "R8");
        for (int i = 0; i < NL; i++) idle(i, "R8");
        // R9: save slot 3, allocate, then restore slot 3 while committing slot 2
        step(0, 0, 1, 3, 0, 0, 0, 0, 0, "R9");
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, "R9");
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, "R9");
        step(0, 0, 0, 0, 1, 2, 1, 3, 0, "R9");
        for (int i = 0; i < NL; i++) idle(i, "R9");
        // R10: legal random traffic, slot 3 live
        live.push_back(3);
        for (int n = 0; n < 3000; n++) begin
            bit a, sv, cm, rs;
            int ss, cs, rss;
            a = ($urandom % 3) != 0;
            rs = (live.size() > 0) && ($urandom % 17 == 0);
            sv = !rs && (live.size() < NC) && ($urandom % 6 == 0);
            cm = (live.size() > (rs ? 1 : 0)) && ($urandom % 7 == 0);
            ss = (live.size() > 0) ? (live[live.size()-1] + 1) % NC : 0;
            cs = (live.size() > 0) ? live[0] : 0;
            rss = (live.size() > 0) ? live[live.size()-1] : 0;
            step(a, $urandom % NL, sv, ss, cm, cs, rs, rss, $urandom % NL, "R10");
            if (cm) void'(live.pop_front());
            if (sv) live.push_back(ss);
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule